// File: doc/BRIEF.md
# Embedded Video Timing Code Decoder

This block sits on a parallel video bus that carries its frame timing inside the data stream, as four-word reference codes mixed in with the pixels. It takes one bus word per clock. It tracks the three-word preamble with a small search machine. When it reaches the status word, it checks the flag bits against their protection bits. Only then does it update its field, vertical-blanking and start/end-of-active outputs.

Each accepted code produces a one-cycle strobe. Each rejected status word produces a one-cycle error strobe instead. The word stream comes out one clock later with a flag that marks the pixels inside the active region. A downstream display or capture stage can use that flag directly as its pixel enable.

The status word layout in the 10-bit view, from the most significant bit down, is as follows:
- bit 9 is a fixed 1;
- bit 8 is F, the field;
- bit 7 is V, vertical blanking;
- bit 6 is H, where 0 means start of active video and 1 means end of active video;
- bits 5..2 are the protection bits P3..P0;
- bits 1..0 are not examined.

With 8-bit video the code sits in the upper bits of the bus.

Top module: `embTimingDecoder`

## Requirements
- R1: A synchronous active-high `rst` forces `fieldOut`=0, `vblankOut`=1, `eavOut`=1, `pixActive`=0, `codeStrobe`=0, `errStrobe`=0, `pixData`=0 and returns the search to idle, so that a partial preamble seen before reset cannot complete a code afterwards.
- R2: A status word is examined only when it directly follows a word whose upper 8 bits are all ones and two words whose upper 8 bits are all zeros.
- R3: A status word is accepted only if bit 9 = 1, P3 = V^H, P2 = F^H, P1 = F^V and P0 = F^V^H. Otherwise `errStrobe` is high for the one cycle after that word, and `fieldOut`, `vblankOut` and `eavOut` keep their values.
- R4: An accepted status word raises `codeStrobe` for exactly one cycle, in the cycle after the word is sampled. In that same cycle `fieldOut`, `vblankOut` and `eavOut` take F, V and H.
- R5: After an accepted code with H=1 (end of active video), no later word is flagged as pixel data until a start code with V=0 is accepted.
- R6: After an accepted code with H=0 and V=0, each following non-code word is flagged active. A start code with V=1 leaves the flag low.
- R7: The words of a timing code are never flagged as pixel data. These are any word whose upper 8 bits are all ones, words sampled while a preamble is partly matched, and the status word.
- R8: If the second or third preamble word is not all-zeros, the search returns to idle. If that word is all-ones, it counts as the first word of a new preamble.
- R9: `pixData` equals the bus word sampled at the previous clock edge, aligned with its `pixActive` flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| vidData | input | DATA_W (10) | Incoming video word |
| pixData | output | DATA_W (10) | Incoming word delayed one clock |
| pixActive | output | 1 | `pixData` is a pixel inside the active region |
| fieldOut | output | 1 | Field bit of the last accepted code |
| vblankOut | output | 1 | Vertical-blanking bit of the last accepted code |
| eavOut | output | 1 | 1 if the last accepted code was end of active video |
| codeStrobe | output | 1 | One-cycle pulse per accepted code |
| errStrobe | output | 1 | One-cycle pulse per rejected status word |

## Verification
The assertions assume the bus changes only between clock edges and that `rst` is high for at least one edge before any stream starts. They also assume the stream never delivers two status slots closer than four words apart, which holds because every code needs its three preamble words. The stimulus drives each word half a cycle before the sampling edge. It places every code after a full preamble or deliberately breaks one, and it starts from a reset, so the past-value checks only ever see words captured after reset.

// File: rtl/embTimingPkg.sv
package embTimingPkg;

  // Progress of the preamble search
  typedef enum logic [1:0] {
    SRCH_IDLE  = 2'd0,
    SRCH_ONES  = 2'd1,
    SRCH_ZERO1 = 2'd2,
    SRCH_ZERO2 = 2'd3
  } srchState_e;

  // Strobes from the search control to the timing datapath
  typedef struct packed {
    logic statusSlot;  // current word is in the status position
    logic codeWord;    // current word belongs to a timing code
  } ctrlStrobe_t;

endpackage

// File: rtl/embTimingCtrl.sv
module embTimingCtrl
  import embTimingPkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CMP_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataIn,
  output ctrlStrobe_t       strobe
);

  localparam int CMP_LSB = DATA_W - CMP_W;

  srchState_e state, stateNext;
  logic       onesWord, zeroWord;

  assign onesWord = &dataIn[DATA_W-1:CMP_LSB];
  assign zeroWord = ~|dataIn[DATA_W-1:CMP_LSB];

  always_comb begin
    stateNext = state;
    unique case (state)
      SRCH_IDLE:  stateNext = onesWord ? SRCH_ONES : SRCH_IDLE;
      SRCH_ONES:  stateNext = zeroWord ? SRCH_ZERO1 : (onesWord ? SRCH_ONES : SRCH_IDLE);
      SRCH_ZERO1: stateNext = zeroWord ? SRCH_ZERO2 : (onesWord ? SRCH_ONES : SRCH_IDLE);
      SRCH_ZERO2: stateNext = SRCH_IDLE;  // status word consumed whatever it holds
      default:    stateNext = SRCH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SRCH_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    strobe.statusSlot = (state == SRCH_ZERO2);
    strobe.codeWord   = (state != SRCH_IDLE) || onesWord;
  end

  // R2: a status slot is reached only through ones, zeros, zeros on the bus
  a_r2_status_after_preamble: assert property (@(posedge clk) disable iff (rst)
    strobe.statusSlot |-> ($past(onesWord, 3) && $past(zeroWord, 2) && $past(zeroWord, 1)));

  // R8: a word of all ones always opens a fresh preamble
  a_r8_ones_restarts: assert property (@(posedge clk) disable iff (rst)
    (onesWord && !strobe.statusSlot) |=> (state == SRCH_ONES));

endmodule

// File: rtl/embTimingPath.sv
module embTimingPath
  import embTimingPkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrlStrobe_t       strobe,
  output logic [DATA_W-1:0] pixData,
  output logic              pixActive,
  output logic              fieldOut,
  output logic              vblankOut,
  output logic              eavOut,
  output logic              codeStrobe,
  output logic              errStrobe
);

  // Field positions counted down from the top of the word
  localparam int POS_ONE = DATA_W - 1;
  localparam int POS_F   = DATA_W - 2;
  localparam int POS_V   = DATA_W - 3;
  localparam int POS_H   = DATA_W - 4;
  localparam int POS_P3  = DATA_W - 5;
  localparam int POS_P0  = DATA_W - 8;

  logic       fBit, vBit, hBit;
  logic [3:0] protRx, protExp;
  logic       protOk, acceptCode;
  logic       inActive;

  assign fBit    = dataIn[POS_F];
  assign vBit    = dataIn[POS_V];
  assign hBit    = dataIn[POS_H];
  assign protRx  = dataIn[POS_P3:POS_P0];
  assign protExp = {vBit ^ hBit, fBit ^ hBit, fBit ^ vBit, fBit ^ vBit ^ hBit};
  assign protOk  = dataIn[POS_ONE] && (protRx == protExp);
  assign acceptCode = strobe.statusSlot && protOk;

  always_ff @(posedge clk) begin
    if (rst) begin
      pixData    <= '0;
      pixActive  <= 1'b0;
      fieldOut   <= 1'b0;
      vblankOut  <= 1'b1;
      eavOut     <= 1'b1;
      codeStrobe <= 1'b0;
      errStrobe  <= 1'b0;
      inActive   <= 1'b0;
    end else begin
      pixData    <= dataIn;
      pixActive  <= inActive && !strobe.codeWord;
      codeStrobe <= acceptCode;
      errStrobe  <= strobe.statusSlot && !protOk;
      if (acceptCode) begin
        fieldOut  <= fBit;
        vblankOut <= vBit;
        eavOut    <= hBit;
        inActive  <= !hBit && !vBit;
      end
    end
  end

  // R4: codes are at least four words apart, so a strobe never lasts two cycles
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    codeStrobe |=> !codeStrobe);

  // R3: a rejected status word leaves the timing levels alone
  a_r3_error_holds_timing: assert property (@(posedge clk) disable iff (rst)
    errStrobe |-> ($stable(fieldOut) && $stable(vblankOut) && $stable(eavOut)));

  // R7: the status word itself is never a pixel
  a_r7_status_not_pixel: assert property (@(posedge clk) disable iff (rst)
    (codeStrobe || errStrobe) |-> !pixActive);

  // R6: pixels appear only after a start code outside vertical blanking
  a_r6_active_needs_sav: assert property (@(posedge clk) disable iff (rst)
    pixActive |-> (!vblankOut && !eavOut));

  // R5: the word after an end code is not a pixel
  a_r5_eav_stops_pixels: assert property (@(posedge clk) disable iff (rst)
    (codeStrobe && eavOut) |=> !pixActive);

  // R9: the data path is a plain one-word delay
  a_r9_data_delay: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pixData == $past(dataIn)));

endmodule

// File: rtl/embTimingDecoder.sv
module embTimingDecoder
  import embTimingPkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CMP_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] vidData,
  output logic [DATA_W-1:0] pixData,
  output logic              pixActive,
  output logic              fieldOut,
  output logic              vblankOut,
  output logic              eavOut,
  output logic              codeStrobe,
  output logic              errStrobe
);

  ctrlStrobe_t strobe;

  embTimingCtrl #(.DATA_W(DATA_W), .CMP_W(CMP_W)) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .dataIn (vidData),
    .strobe (strobe)
  );

  embTimingPath #(.DATA_W(DATA_W)) i_path (
    .clk        (clk),
    .rst        (rst),
    .dataIn     (vidData),
    .strobe     (strobe),
    .pixData    (pixData),
    .pixActive  (pixActive),
    .fieldOut   (fieldOut),
    .vblankOut  (vblankOut),
    .eavOut     (eavOut),
    .codeStrobe (codeStrobe),
    .errStrobe  (errStrobe)
  );

  // R3/R4: a status slot gives at most one of the two verdicts
  a_r3_one_verdict: assert property (@(posedge clk) disable iff (rst)
    !(codeStrobe && errStrobe));

endmodule

// File: tb/test_embTimingDecoder.sv
module test_embTimingDecoder;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 49;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] vidData = '0;
  logic [9:0] pixData;
  logic       pixActive, fieldOut, vblankOut, eavOut, codeStrobe, errStrobe;

  int  total = 0;
  int  fails = 0;
  bit  done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  embTimingDecoder i_embTimingDecoder (
    .clk(clk), .rst(rst), .vidData(vidData), .pixData(pixData),
    .pixActive(pixActive), .fieldOut(fieldOut), .vblankOut(vblankOut),
    .eavOut(eavOut), .codeStrobe(codeStrobe), .errStrobe(errStrobe)
  );

  // Entry: {word[9:0], pix, strobe, err, F, V, H} expected after the word is sampled.
  // Valid status words: 200 274 2AC 2D8 31C 368 3B0 3C4 (F,V,H = 000..111).
  localparam logic [15:0] VEC [NVEC] = '{
    {10'h080, 6'b000011}, // 0  blanking after reset
    {10'h3FF, 6'b000011}, // 1  R2 preamble
    {10'h000, 6'b000011}, // 2
    {10'h000, 6'b000011}, // 3
    {10'h200, 6'b010000}, // 4  R4 start code F0 V0
    {10'h123, 6'b100000}, // 5  R6 pixel
    {10'h045, 6'b100000}, // 6  R6 pixel
    {10'h3FF, 6'b000000}, // 7  R7 code word
    {10'h000, 6'b000000}, // 8
    {10'h000, 6'b000000}, // 9
    {10'h274, 6'b010001}, // 10 R5 end code
    {10'h080, 6'b000001}, // 11 R5 no pixel
    {10'h3FF, 6'b000001}, // 12
    {10'h000, 6'b000001}, // 13
    {10'h000, 6'b000001}, // 14
    {10'h204, 6'b001001}, // 15 R3 bad protection
    {10'h100, 6'b000001}, // 16 R3 nothing changed
    {10'h3FF, 6'b000001}, // 17
    {10'h000, 6'b000001}, // 18
    {10'h000, 6'b000001}, // 19
    {10'h2AC, 6'b010010}, // 20 R6 start code in vblank
    {10'h150, 6'b000010}, // 21 R6 no pixel in vblank
    {10'h3FF, 6'b000010}, // 22
    {10'h000, 6'b000010}, // 23
    {10'h3FF, 6'b000010}, // 24 R8 restart on third word
    {10'h000, 6'b000010}, // 25
    {10'h000, 6'b000010}, // 26
    {10'h31C, 6'b010100}, // 27 R8 code after restart
    {10'h0AA, 6'b100100}, // 28
    {10'h3FF, 6'b000100}, // 29
    {10'h040, 6'b000100}, // 30 R8 broken, R7 not pixel
    {10'h011, 6'b100100}, // 31 back to pixels
    {10'h3FF, 6'b000100}, // 32
    {10'h000, 6'b000100}, // 33
    {10'h000, 6'b000100}, // 34
    {10'h11C, 6'b001100}, // 35 R3 top bit clear
    {10'h055, 6'b100100}, // 36 R3 active kept
    {10'h3FF, 6'b000100}, // 37
    {10'h000, 6'b000100}, // 38
    {10'h000, 6'b000100}, // 39
    {10'h3C4, 6'b010111}, // 40 R4 F1 V1 H1
    {10'h0AA, 6'b000111}, // 41
    {10'h3FF, 6'b000111}, // 42
    {10'h000, 6'b000111}, // 43
    {10'h3FF, 6'b000111}, // 44 R8 restart on third word
    {10'h000, 6'b000111}, // 45
    {10'h000, 6'b000111}, // 46
    {10'h368, 6'b010101}, // 47 R4 F1 V0 H1
    {10'h222, 6'b000101}  // 48
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic feed(input logic [9:0] w);
    vidData = w;
    @(negedge clk);
  endtask

  function automatic logic [5:0] flags();
    return {pixActive, codeStrobe, errStrobe, fieldOut, vblankOut, eavOut};
  endfunction

  initial begin
    repeat (1000 * CLK_PERIOD) #1;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    vidData = 10'h3FF;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset flags", {10'h0, flags()}, {10'h0, 6'b000011});
    check("R1 reset data", {6'h0, pixData}, 16'h0);
    rst = 1'b0;

    // Table walk: R2..R9
    for (int i = 0; i < NVEC; i++) begin
      feed(VEC[i][15:6]);
      check($sformatf("R2/R3/R4/R5/R6/R7/R8 vec%0d flags", i), {10'h0, flags()}, {10'h0, VEC[i][5:0]});
      check($sformatf("R9 vec%0d data", i), {6'h0, pixData}, {6'h0, VEC[i][15:6]});
    end

    // R1: reset in the middle of a preamble abandons it
    feed(10'h3FF);
    feed(10'h000);
    rst = 1'b1;
    feed(10'h000);
    check("R1 mid reset flags", {10'h0, flags()}, {10'h0, 6'b000011});
    rst = 1'b0;
    feed(10'h000);
    feed(10'h200);
    check("R1 no code after reset", {10'h0, flags()}, {10'h0, 6'b000011});
    feed(10'h123);
    check("R1 still blanking", {10'h0, flags()}, {10'h0, 6'b000011});

    // R6/R7: run of ones words during active never flagged
    feed(10'h3FF); feed(10'h000); feed(10'h000); feed(10'h31C);
    check("R4 code F1", {10'h0, flags()}, {10'h0, 6'b010100});
    feed(10'h3FF);
    check("R7 ones word", {10'h0, flags()}, {10'h0, 6'b000100});
    feed(10'h3FF);
    check("R7 second ones word", {10'h0, flags()}, {10'h0, 6'b000100});
    feed(10'h0F0);
    check("R8 broken then pixel-free", {10'h0, flags()}, {10'h0, 6'b000100});
    feed(10'h0F1);
    check("R6 pixel resumes", {10'h0, flags()}, {10'h0, 6'b100100});

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule